// File: doc/BRIEF.md
# PTP Frame Timestamp Capture Latch

This block records the local 64-bit time at the moment an event frame passes the MAC. There is one capture slot for the transmit direction and one for the receive direction. Each slot holds one timestamp and a valid flag. Once a slot is filled it stays locked: the stored value is held until software reads the high word, and that read releases it. Because of this, only one frame per direction can own a stored timestamp at any time.

The upstream frame parser supplies a one-cycle strobe per frame together with parsed sideband fields. For transmit, the sideband is a per-frame stamp request. For receive, the sideband carries the L2/UDP flags, the EtherType, the UDP destination port, the PTP version, the V2 messageType and the V1 control byte. On receive, a mode field selects how frames qualify. The V1 mode accepts UDP frames whose control byte equals one programmed code. The V2 mode accepts every V2 event message, including the peer-delay messages. When a receive frame wins the slot, the block raises a descriptor status bit for that frame. A frame that arrives while the slot is locked is dropped silently.

Top module: `ts_capture_latch`

## Requirements
- R1: During and right after synchronous reset, both valid flags are 0, both stamps are 0 and `rx_desc_ts` is 0.
- R2: On a cycle where `tx_enable`, `tx_frame_stb` and `tx_stamp_req` are all 1 and the transmit slot is empty, `tx_stamp_valid` is 1 from the next cycle on, and `tx_stamp` equals the `time_now` of the strobe cycle.
- R3: A direction whose enable input is 0 captures nothing, whatever frames arrive.
- R4: While a slot is valid, further qualifying frames leave its stamp unchanged. A receive frame dropped this way gets `rx_desc_ts` = 0.
- R5: A one-cycle high-word read pulse (`tx_hi_read`/`rx_hi_read`) on a valid slot clears its flag in the next cycle, and the next qualifying frame is then captured. A read pulse on an empty slot has no effect.
- R6: `rx_mode` = 2'b01 (V1 over UDP) qualifies a frame only when all of these hold: `rx_is_udp` is 1, `rx_udp_dport` equals `rx_match_cfg[31:16]`, `rx_ptp_ver` is 1, and `rx_v1_ctrl` equals `rx_match_cfg[7:0]` (Sync is 0x00, Delay_Req is 0x01). Only one code is selected at a time.
- R7: `rx_mode` = 2'b10 (V2 event) qualifies a frame when `rx_ptp_ver` is 2 and `rx_msg_type` is 0 to 3, which covers Sync, Delay_Req, Pdelay_Req and Pdelay_Resp. The frame must also match on one of two paths: either it is UDP with a port match on `rx_match_cfg[31:16]`, or it is L2 with EtherType 0x88F7 while `l2_filter_en` and `l2_stamp_en` are both 1. General messages (types 8 to 15) never qualify.
- R8: `rx_mode` = 2'b00 (off) and `rx_mode` = 2'b11 (a request to capture all frames, which is unsupported) qualify no frame.
- R9: `rx_desc_ts` pulses for exactly one cycle, in the cycle after a receive strobe, if and only if that frame was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Free-running local time |
| tx_enable | input | 1 | Transmit capture enable |
| rx_enable | input | 1 | Receive capture enable |
| rx_mode | input | 2 | Receive qualify mode: 00 off, 01 V1 UDP, 10 V2 event, 11 unsupported |
| rx_match_cfg | input | 32 | [31:16] UDP port, [7:0] V1 control code |
| l2_filter_en | input | 1 | EtherType filter enable |
| l2_stamp_en | input | 1 | EtherType filter timestamp enable |
| tx_frame_stb | input | 1 | Transmit frame strobe |
| tx_stamp_req | input | 1 | Transmit frame asks for a stamp |
| rx_frame_stb | input | 1 | Receive frame strobe |
| rx_is_l2 | input | 1 | Frame is a bare L2 frame |
| rx_ethertype | input | 16 | Frame EtherType |
| rx_is_udp | input | 1 | Frame carries UDP |
| rx_udp_dport | input | 16 | UDP destination port |
| rx_ptp_ver | input | 4 | PTP version field |
| rx_msg_type | input | 4 | V2 messageType |
| rx_v1_ctrl | input | 8 | V1 control byte |
| tx_hi_read | input | 1 | Transmit stamp high-word read pulse |
| rx_hi_read | input | 1 | Receive stamp high-word read pulse |
| tx_stamp_valid | output | 1 | Transmit slot holds a stamp |
| tx_stamp | output | 64 | Transmit stamp |
| rx_stamp_valid | output | 1 | Receive slot holds a stamp |
| rx_stamp | output | 64 | Receive stamp |
| rx_desc_ts | output | 1 | Descriptor timestamp status for the last strobed frame |

## Verification
The bench drives receive frames with random mixes of mode, version, messageType, V1 control byte, port and EtherType. The fields are biased toward near-misses, so that a single wrong field (wrong port, V1 in V2 mode, a general message, one filter bit missing) is separated from a true match. Random read pulses and bursts of back-to-back frames tell a correct lock and release apart from a slot that overwrites its stamp or drops frames after release. Directed cases cover the peer-delay types, both V1 codes, the unsupported mode and a disabled direction.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    RXM_OFF    = 2'b00,
    RXM_V1_UDP = 2'b01,
    RXM_V2_EVT = 2'b10,
    RXM_ALL    = 2'b11
  } rx_mode_e;

  localparam logic [15:0] PTP_ETHERTYPE = 16'h88F7;
  localparam logic [3:0]  V2_EVENT_LAST = 4'd3;
  localparam logic [3:0]  VER_ONE       = 4'd1;
  localparam logic [3:0]  VER_TWO       = 4'd2;
  localparam int          NUM_DIR       = 2;
  localparam int          DIR_TX        = 0;
  localparam int          DIR_RX        = 1;
endpackage

// File: rtl/ts_rx_qualify.sv
module ts_rx_qualify
  import ts_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int CODE_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              l2_filter_en,
  input  logic              l2_stamp_en,
  input  logic              is_l2,
  input  logic [15:0]       ethertype,
  input  logic              is_udp,
  input  logic [PORT_W-1:0] udp_dport,
  input  logic [3:0]        ptp_ver,
  input  logic [3:0]        msg_type,
  input  logic [CODE_W-1:0] v1_ctrl,
  output logic              hit
);
  logic port_ok;
  logic l2_ok;
  logic v1_ok;
  logic v2_ok;

  always_comb begin
    port_ok = is_udp && (udp_dport == cfg_port);
    l2_ok   = is_l2 && (ethertype == PTP_ETHERTYPE) && l2_filter_en && l2_stamp_en;
    v1_ok   = port_ok && (ptp_ver == VER_ONE) && (v1_ctrl == cfg_code);
    v2_ok   = (port_ok || l2_ok) && (ptp_ver == VER_TWO) && (msg_type <= V2_EVENT_LAST);
    unique case (rx_mode_e'(mode))
      RXM_V1_UDP: hit = v1_ok;
      RXM_V2_EVT: hit = v2_ok;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              req,
  input  logic              release_rd,
  input  logic [TIME_W-1:0] time_in,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic              took
);
  logic grab;

  always_comb grab = enable && req && !valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      stamp <= '0;
      took  <= 1'b0;
    end else begin
      took <= grab;
      if (grab) begin
        valid <= 1'b1;
        stamp <= time_in;
      end else if (release_rd) begin
        valid <= 1'b0;
      end
    end
  end

  a_r4_lock_hold: assert property (@(posedge clk) disable iff (rst)
    valid && !release_rd |=> valid && $stable(stamp));
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    valid && release_rd |=> !valid);
  a_r3_disabled_no_capture: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !$rose(valid));
  a_r9_took_means_new: assert property (@(posedge clk) disable iff (rst)
    took |-> $rose(valid));
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int PORT_W = 16,
  parameter int CFG_W  = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_now,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic [1:0]        rx_mode,
  input  logic [CFG_W-1:0]  rx_match_cfg,
  input  logic              l2_filter_en,
  input  logic              l2_stamp_en,
  input  logic              tx_frame_stb,
  input  logic              tx_stamp_req,
  input  logic              rx_frame_stb,
  input  logic              rx_is_l2,
  input  logic [15:0]       rx_ethertype,
  input  logic              rx_is_udp,
  input  logic [PORT_W-1:0] rx_udp_dport,
  input  logic [3:0]        rx_ptp_ver,
  input  logic [3:0]        rx_msg_type,
  input  logic [CODE_W-1:0] rx_v1_ctrl,
  input  logic              tx_hi_read,
  input  logic              rx_hi_read,
  output logic              tx_stamp_valid,
  output logic [TIME_W-1:0] tx_stamp,
  output logic              rx_stamp_valid,
  output logic [TIME_W-1:0] rx_stamp,
  output logic              rx_desc_ts
);
  localparam int PORT_LSB = CFG_W - PORT_W;

  logic              rx_hit;
  logic [NUM_DIR-1:0] d_en, d_req, d_rel, d_valid, d_took;
  logic [TIME_W-1:0]  d_stamp [NUM_DIR];

  ts_rx_qualify #(.PORT_W(PORT_W), .CODE_W(CODE_W)) u_qual (
    .mode         (rx_mode),
    .cfg_port     (rx_match_cfg[CFG_W-1:PORT_LSB]),
    .cfg_code     (rx_match_cfg[CODE_W-1:0]),
    .l2_filter_en (l2_filter_en),
    .l2_stamp_en  (l2_stamp_en),
    .is_l2        (rx_is_l2),
    .ethertype    (rx_ethertype),
    .is_udp       (rx_is_udp),
    .udp_dport    (rx_udp_dport),
    .ptp_ver      (rx_ptp_ver),
    .msg_type     (rx_msg_type),
    .v1_ctrl      (rx_v1_ctrl),
    .hit          (rx_hit)
  );

  always_comb begin
    d_en[DIR_TX]  = tx_enable;
    d_req[DIR_TX] = tx_frame_stb && tx_stamp_req;
    d_rel[DIR_TX] = tx_hi_read;
    d_en[DIR_RX]  = rx_enable;
    d_req[DIR_RX] = rx_frame_stb && rx_hit;
    d_rel[DIR_RX] = rx_hi_read;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    ts_capture_slot #(.TIME_W(TIME_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .enable     (d_en[d]),
      .req        (d_req[d]),
      .release_rd (d_rel[d]),
      .time_in    (time_now),
      .valid      (d_valid[d]),
      .stamp      (d_stamp[d]),
      .took       (d_took[d])
    );
  end

  assign tx_stamp_valid = d_valid[DIR_TX];
  assign tx_stamp       = d_stamp[DIR_TX];
  assign rx_stamp_valid = d_valid[DIR_RX];
  assign rx_stamp       = d_stamp[DIR_RX];
  assign rx_desc_ts     = d_took[DIR_RX];

  a_r8_off_no_mark: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == 2'b00 || rx_mode == 2'b11) |=> !rx_desc_ts);
  a_r9_mark_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !rx_frame_stb |=> !rx_desc_ts);
  a_r4_locked_no_mark: assert property (@(posedge clk) disable iff (rst)
    rx_stamp_valid |=> !rx_desc_ts);
  a_r2_tx_no_req_no_rise: assert property (@(posedge clk) disable iff (rst)
    !(tx_frame_stb && tx_stamp_req) |=> !$rose(tx_stamp_valid));
endmodule

// File: tb/ts_capture_latch_bench.sv
module ts_capture_latch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = 64'd0;
  logic        tx_enable = 0, rx_enable = 0;
  logic [1:0]  rx_mode = 2'b00;
  logic [31:0] rx_match_cfg = 32'd0;
  logic        l2_filter_en = 0, l2_stamp_en = 0;
  logic        tx_frame_stb = 0, tx_stamp_req = 0, rx_frame_stb = 0;
  logic        rx_is_l2 = 0, rx_is_udp = 0;
  logic [15:0] rx_ethertype = 16'd0, rx_udp_dport = 16'd0;
  logic [3:0]  rx_ptp_ver = 4'd0, rx_msg_type = 4'd0;
  logic [7:0]  rx_v1_ctrl = 8'd0;
  logic        tx_hi_read = 0, rx_hi_read = 0;
  logic        tx_stamp_valid, rx_stamp_valid, rx_desc_ts;
  logic [63:0] tx_stamp, rx_stamp;

  int checks = 0, errors = 0;
  bit done = 0;
  logic        m_tx_v = 0, m_rx_v = 0, m_mark = 0;
  logic [63:0] m_tx_s = 0, m_rx_s = 0;

  always #10 clk = ~clk;

  ts_capture_latch u_ts_capture_latch (
    .clk(clk), .rst(rst), .time_now(time_now),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .rx_mode(rx_mode),
    .rx_match_cfg(rx_match_cfg), .l2_filter_en(l2_filter_en), .l2_stamp_en(l2_stamp_en),
    .tx_frame_stb(tx_frame_stb), .tx_stamp_req(tx_stamp_req), .rx_frame_stb(rx_frame_stb),
    .rx_is_l2(rx_is_l2), .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp),
    .rx_udp_dport(rx_udp_dport), .rx_ptp_ver(rx_ptp_ver), .rx_msg_type(rx_msg_type),
    .rx_v1_ctrl(rx_v1_ctrl), .tx_hi_read(tx_hi_read), .rx_hi_read(rx_hi_read),
    .tx_stamp_valid(tx_stamp_valid), .tx_stamp(tx_stamp),
    .rx_stamp_valid(rx_stamp_valid), .rx_stamp(rx_stamp), .rx_desc_ts(rx_desc_ts)
  );

  function automatic bit rx_qual();
    bit port_ok, l2_ok;
    port_ok = rx_is_udp && (rx_udp_dport == rx_match_cfg[31:16]);
    l2_ok = rx_is_l2 && rx_ethertype == 16'h88F7 && l2_filter_en && l2_stamp_en;
    if (rx_mode == 2'b01) return port_ok && rx_ptp_ver == 4'd1 && rx_v1_ctrl == rx_match_cfg[7:0];
    if (rx_mode == 2'b10) return (port_ok || l2_ok) && rx_ptp_ver == 4'd2 && rx_msg_type <= 4'd3;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Models one clock with the inputs as currently driven, then compares every output.
  task automatic cycle(string tag);
    bit txc, rxc;
    txc = tx_enable && tx_frame_stb && tx_stamp_req && !m_tx_v;
    rxc = rx_enable && rx_frame_stb && rx_qual() && !m_rx_v;
    m_mark = rxc;
    if (txc) begin m_tx_v = 1; m_tx_s = time_now; end
    else if (tx_hi_read) m_tx_v = 0;
    if (rxc) begin m_rx_v = 1; m_rx_s = time_now; end
    else if (rx_hi_read) m_rx_v = 0;
    @(posedge clk); @(negedge clk);
    chk(tag, "tx_valid", {63'd0, tx_stamp_valid}, {63'd0, m_tx_v});
    chk(tag, "tx_stamp", tx_stamp, m_tx_s);
    chk(tag, "rx_valid", {63'd0, rx_stamp_valid}, {63'd0, m_rx_v});
    chk(tag, "rx_stamp", rx_stamp, m_rx_s);
    chk(tag, "rx_desc_ts", {63'd0, rx_desc_ts}, {63'd0, m_mark});
    tx_frame_stb = 0; rx_frame_stb = 0; tx_hi_read = 0; rx_hi_read = 0;
    time_now = time_now + 64'd7;
  endtask

  task automatic rx_frame(bit udp, bit l2, logic [15:0] port, logic [15:0] et,
                          logic [3:0] ver, logic [3:0] mt, logic [7:0] ctl);
    rx_frame_stb = 1; rx_is_udp = udp; rx_is_l2 = l2; rx_udp_dport = port;
    rx_ethertype = et; rx_ptp_ver = ver; rx_msg_type = mt; rx_v1_ctrl = ctl;
  endtask

  task automatic rx_release(string tag);
    rx_hi_read = 1; cycle(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h1588;
    void'($urandom(seed));
    time_now = 64'h1234_0000_0000_0100;
    @(negedge clk);
    // R1: reset state, with strobes present during reset
    tx_enable = 1; rx_enable = 1; tx_frame_stb = 1; tx_stamp_req = 1;
    @(posedge clk); @(negedge clk);
    chk("R1", "tx_valid", {63'd0, tx_stamp_valid}, 64'd0);
    chk("R1", "rx_valid", {63'd0, rx_stamp_valid}, 64'd0);
    chk("R1", "tx_stamp", tx_stamp, 64'd0);
    chk("R1", "rx_desc_ts", {63'd0, rx_desc_ts}, 64'd0);
    tx_frame_stb = 0; tx_enable = 0; rx_enable = 0;
    rst = 0;
    cycle("R1");

    // R3: disabled directions capture nothing
    rx_mode = 2'b10; rx_match_cfg = {16'd319, 16'h0000};
    tx_frame_stb = 1; tx_stamp_req = 1;
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'd0, 8'd0);
    cycle("R3");

    // R2: transmit capture, and R4 lock on transmit
    tx_enable = 1; tx_frame_stb = 1; tx_stamp_req = 1; cycle("R2");
    tx_frame_stb = 1; tx_stamp_req = 1; cycle("R4");
    tx_frame_stb = 1; tx_stamp_req = 0; tx_hi_read = 1; cycle("R5");
    tx_frame_stb = 1; tx_stamp_req = 0; cycle("R2");

    // R7: V2 event types including peer delay, via UDP and L2
    rx_enable = 1;
    for (int t = 0; t < 4; t++) begin
      rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'(t), 8'd0); cycle("R7");
      rx_release("R5");
    end
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'd8, 8'd0); cycle("R7");
    l2_filter_en = 1; l2_stamp_en = 0;
    rx_frame(0, 1, 16'd0, 16'h88F7, 4'd2, 4'd2, 8'd0); cycle("R7");
    l2_stamp_en = 1;
    rx_frame(0, 1, 16'd0, 16'h88F7, 4'd2, 4'd3, 8'd0); cycle("R7");
    // R4: locked, second frame dropped with mark clear
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'd0, 8'd0); cycle("R4");
    rx_release("R5");
    rx_release("R5");

    // R6: V1 with Delay_Req code selected; Sync must not match
    rx_mode = 2'b01; rx_match_cfg = {16'd319, 8'h00, 8'h01};
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd1, 4'd0, 8'h00); cycle("R6");
    rx_frame(1, 0, 16'd320, 16'h0800, 4'd1, 4'd0, 8'h01); cycle("R6");
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'd1, 8'h01); cycle("R6");
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd1, 4'd0, 8'h01); cycle("R6");
    rx_release("R5");

    // R8: off and unsupported modes
    rx_mode = 2'b11;
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd2, 4'd0, 8'h01); cycle("R8");
    rx_mode = 2'b00;
    rx_frame(1, 0, 16'd319, 16'h0800, 4'd1, 4'd0, 8'h01); cycle("R8");

    // Random phase: R9 mark exactness and all qualification rules
    for (int i = 0; i < 2000; i++) begin
      if (i % 64 == 0) begin
        rx_mode = 2'($urandom % 4);
        rx_match_cfg = {(($urandom % 2) ? 16'd319 : 16'd320), 8'h00, 8'($urandom % 2)};
        l2_filter_en = 1'($urandom); l2_stamp_en = 1'($urandom);
        rx_enable = ($urandom % 8) != 0; tx_enable = ($urandom % 8) != 0;
      end
      if ($urandom % 2)
        rx_frame(1'($urandom), 1'($urandom), (($urandom % 4) != 0) ? 16'd319 : 16'($urandom),
                 (($urandom % 4) != 0) ? 16'h88F7 : 16'h0800, 4'(1 + $urandom % 2),
                 4'(($urandom % 3 == 0) ? 8 + $urandom % 8 : $urandom % 4), 8'($urandom % 3));
      tx_frame_stb = ($urandom % 3) == 0; tx_stamp_req = 1'($urandom);
      rx_hi_read = ($urandom % 4) == 0; tx_hi_read = ($urandom % 4) == 0;
      time_now = {32'($urandom), 32'($urandom)};
      cycle("R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule